// File: doc/BRIEF.md
# DAC Start-Up Sample Gate

This block sits in the playback sample path just ahead of the DAC. When the DAC power enable rises and both ADC power enables are low, it starts an initialization window. The window is timed in sample strobes, and while it runs both channels' samples are replaced with two's-complement zero. During the same window it raises a hold flag so the automatic level control keeps the gain it was programmed with. On the last strobe of the window it gives a one-cycle load pulse, and the level control starts adapting from that gain.

Once the window has ended, or when it was skipped because an ADC was already powered, samples pass through unchanged. The output volume then moves one code per sample strobe from its default code toward the programmed code, so it never jumps. A link input lets the left volume setting drive both channels.

Top module: `dac_start_gate`

## Requirements
- R1: After reset, `init_busy`, `alc_hold` and `alc_load` are 0, both data outputs are 0, and both volume outputs equal the default code `VOL_DEFAULT` (0x18).
- R2: If `dac_en` goes from 0 to 1 while `adc_l_en` and `adc_r_en` are both 0, `init_busy` goes high at the next clock edge. It then stays high for exactly `INIT_LEN` (1059) sample strobes. A strobe in the cycle where `dac_en` rises is not counted.
- R3: The data outputs are 0 in the cycle where a window starts and in every cycle where `init_busy` is 1. In every other cycle with `dac_en` at 1, each data output equals its input in the same cycle.
- R4: If `adc_l_en` or `adc_r_en` is 1 in the cycle where `dac_en` rises, no window starts and samples pass through from that cycle onward.
- R5: While `dac_en` is 0, the data outputs are 0. At the next edge the window and its strobe count are cleared and the volume outputs return to the default code. A later rise of `dac_en` starts a full-length window again.
- R6: `alc_hold` equals `alc_en` AND `dac_en` AND (window starting this cycle OR `init_busy`).
- R7: `alc_load` is 1 for one cycle: the cycle that holds the final counted strobe of a window, and only when `alc_en` is 1.
- R8: The volume outputs change only in passing cycles that have a sample strobe. Each such strobe moves a volume output by one code toward its target. The change shows one edge after the strobe.
- R9: The left target is always `vol_l`. The right target is `vol_l` when `vol_link` is 1 and `vol_r` when `vol_link` is 0.
- R10: While `dac_en` stays at 1, changes on the ADC enables never start a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dac_en | input | 1 | DAC power enable |
| adc_l_en | input | 1 | Left ADC power enable |
| adc_r_en | input | 1 | Right ADC power enable |
| smp_stb | input | 1 | One-cycle sample strobe |
| alc_en | input | 1 | Level control enabled |
| vol_link | input | 1 | 1: left volume drives both channels |
| vol_l | input | VOL_W | Left (or common) volume target |
| vol_r | input | VOL_W | Right volume target |
| din_l | input | DATA_W | Left sample in (signed) |
| din_r | input | DATA_W | Right sample in (signed) |
| dout_l | output | DATA_W | Gated left sample |
| dout_r | output | DATA_W | Gated right sample |
| init_busy | output | 1 | Initialization window running |
| alc_hold | output | 1 | Level control must hold its gain |
| alc_load | output | 1 | Level control resumes from programmed gain |
| vol_out_l | output | VOL_W | Ramped left volume |
| vol_out_r | output | VOL_W | Ramped right volume |

## Verification
The gated data, `alc_hold` and `alc_load` depend on inputs in the same cycle and on state from the previous edge. They are therefore compared in the same cycle as the stimulus. `init_busy` and the volume outputs are registered and move one edge after the enable rise or the strobe that causes the change. The bench drives inputs just after a rising edge and updates a behavioural model at each rising edge. It compares every output at the falling edge, when both inputs and state are settled. Window length is measured by counting strobes seen while `init_busy` is high.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_INIT = 2'd1,
      ST_RUN  = 2'd2
   } dsg_state_e;

   localparam int unsigned NCH = 2;
endpackage

// File: rtl/dsg_init_timer.sv
module dsg_init_timer
   import dsg_pkg::*;
#(
   parameter int unsigned INIT_LEN = 1059
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dac_en,
   input  logic adc_any,
   input  logic smp_stb,
   output logic busy,
   output logic window,
   output logic pass,
   output logic last_stb
);
   localparam int unsigned CNT_W = (INIT_LEN > 2) ? $clog2(INIT_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_LEN - 1);

   dsg_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start;

   assign start    = dac_en && (state_q == ST_OFF) && !adc_any;
   assign last_stb = (state_q == ST_INIT) && smp_stb && (cnt_q == CNT_LAST);
   assign busy     = (state_q == ST_INIT);
   assign window   = dac_en && (start || busy);
   assign pass     = dac_en && ((state_q == ST_RUN) || ((state_q == ST_OFF) && adc_any));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_OFF;
         cnt_q   <= '0;
      end else if (!dac_en) begin
         state_q <= ST_OFF;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_OFF: begin
               state_q <= adc_any ? ST_RUN : ST_INIT;
               cnt_q   <= '0;
            end
            ST_INIT: begin
               if (smp_stb) begin
                  if (cnt_q == CNT_LAST) begin
                     state_q <= ST_RUN;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/dsg_sample_gate.sv
module dsg_sample_gate #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              pass,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_comb begin
      dout = '0;
      if (pass) dout = din;
   end
endmodule

// File: rtl/dsg_vol_ramp.sv
module dsg_vol_ramp #(
   parameter int unsigned VOL_W       = 8,
   parameter int unsigned VOL_DEFAULT = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dac_en,
   input  logic             pass,
   input  logic             smp_stb,
   input  logic [VOL_W-1:0] target,
   output logic [VOL_W-1:0] vol
);
   localparam logic [VOL_W-1:0] VOL_RST = VOL_W'(VOL_DEFAULT);

   logic [VOL_W-1:0] cur_q;
   logic             step_en;

   assign step_en = pass && smp_stb && (cur_q != target);
   assign vol     = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= VOL_RST;
      end else if (!dac_en) begin
         cur_q <= VOL_RST;
      end else if (step_en) begin
         if (cur_q < target) cur_q <= cur_q + 1'b1;
         else                cur_q <= cur_q - 1'b1;
      end
   end
endmodule

// File: rtl/dac_start_gate.sv
module dac_start_gate
   import dsg_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned VOL_W       = 8,
   parameter int unsigned INIT_LEN    = 1059,
   parameter int unsigned VOL_DEFAULT = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dac_en,
   input  logic              adc_l_en,
   input  logic              adc_r_en,
   input  logic              smp_stb,
   input  logic              alc_en,
   input  logic              vol_link,
   input  logic [VOL_W-1:0]  vol_l,
   input  logic [VOL_W-1:0]  vol_r,
   input  logic [DATA_W-1:0] din_l,
   input  logic [DATA_W-1:0] din_r,
   output logic [DATA_W-1:0] dout_l,
   output logic [DATA_W-1:0] dout_r,
   output logic              init_busy,
   output logic              alc_hold,
   output logic              alc_load,
   output logic [VOL_W-1:0]  vol_out_l,
   output logic [VOL_W-1:0]  vol_out_r
);
   if (INIT_LEN < 2)          begin : g_bad_len   $error("INIT_LEN must be at least 2");          end
   if (DATA_W < 2)            begin : g_bad_dw    $error("DATA_W must be at least 2");            end
   if (VOL_W < 2)             begin : g_bad_vw    $error("VOL_W must be at least 2");             end
   if (VOL_DEFAULT >= (1 << VOL_W)) begin : g_bad_def $error("VOL_DEFAULT does not fit VOL_W"); end

   logic busy, window, pass, last_stb;

   dsg_init_timer #(.INIT_LEN(INIT_LEN)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .dac_en   (dac_en),
      .adc_any  (adc_l_en | adc_r_en),
      .smp_stb  (smp_stb),
      .busy     (busy),
      .window   (window),
      .pass     (pass),
      .last_stb (last_stb)
   );

   assign init_busy = busy;
   assign alc_hold  = alc_en && window;
   assign alc_load  = alc_en && dac_en && last_stb;

   logic [DATA_W-1:0] din_a  [NCH];
   logic [DATA_W-1:0] dout_a [NCH];
   logic [VOL_W-1:0]  tgt_a  [NCH];
   logic [VOL_W-1:0]  vol_a  [NCH];

   assign din_a[0] = din_l;
   assign din_a[1] = din_r;
   assign tgt_a[0] = vol_l;
   assign tgt_a[1] = vol_link ? vol_l : vol_r;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      dsg_sample_gate #(.DATA_W(DATA_W)) u_gate (
         .pass (pass),
         .din  (din_a[ch]),
         .dout (dout_a[ch])
      );
      dsg_vol_ramp #(.VOL_W(VOL_W), .VOL_DEFAULT(VOL_DEFAULT)) u_ramp (
         .clk     (clk),
         .rst_n   (rst_n),
         .dac_en  (dac_en),
         .pass    (pass),
         .smp_stb (smp_stb),
         .target  (tgt_a[ch]),
         .vol     (vol_a[ch])
      );
   end

   assign dout_l    = dout_a[0];
   assign dout_r    = dout_a[1];
   assign vol_out_l = vol_a[0];
   assign vol_out_r = vol_a[1];
endmodule

// File: rtl/dsg_checker.sv
module dsg_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned VOL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dac_en,
   input logic              adc_l_en,
   input logic              adc_r_en,
   input logic              smp_stb,
   input logic              alc_en,
   input logic [DATA_W-1:0] dout_l,
   input logic [DATA_W-1:0] dout_r,
   input logic              init_busy,
   input logic              alc_hold,
   input logic              alc_load,
   input logic [VOL_W-1:0]  vol_out_l,
   input logic [VOL_W-1:0]  vol_out_r
);
   AST_ZERO_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy |-> (dout_l == '0 && dout_r == '0)); // R3
   AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_en |-> (dout_l == '0 && dout_r == '0)); // R5
   AST_START_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dac_en) && !adc_l_en && !adc_r_en) |=> init_busy); // R2
   AST_SKIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dac_en) && (adc_l_en || adc_r_en)) |=> !init_busy); // R4
   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_en |=> !init_busy); // R5
   AST_HOLD_NEEDS_ALC: assert property (@(posedge clk) disable iff (!rst_n)
      alc_hold |-> (alc_en && dac_en)); // R6
   AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      alc_load |=> !alc_load); // R7
   AST_LOAD_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      alc_load |=> !init_busy); // R7
   AST_VOL_STILL_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_en && !smp_stb) |=> ($stable(vol_out_l) && $stable(vol_out_r))); // R8
   AST_VOL_ONE_STEP_L: assert property (@(posedge clk) disable iff (!rst_n)
      dac_en |=> (vol_out_l == $past(vol_out_l) ||
                  vol_out_l == VOL_W'($past(vol_out_l) + 1'b1) ||
                  vol_out_l == VOL_W'($past(vol_out_l) - 1'b1))); // R8
   AST_VOL_ONE_STEP_R: assert property (@(posedge clk) disable iff (!rst_n)
      dac_en |=> (vol_out_r == $past(vol_out_r) ||
                  vol_out_r == VOL_W'($past(vol_out_r) + 1'b1) ||
                  vol_out_r == VOL_W'($past(vol_out_r) - 1'b1))); // R8
endmodule

bind dac_start_gate dsg_checker #(.DATA_W(DATA_W), .VOL_W(VOL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dac_en    (dac_en),
   .adc_l_en  (adc_l_en),
   .adc_r_en  (adc_r_en),
   .smp_stb   (smp_stb),
   .alc_en    (alc_en),
   .dout_l    (dout_l),
   .dout_r    (dout_r),
   .init_busy (init_busy),
   .alc_hold  (alc_hold),
   .alc_load  (alc_load),
   .vol_out_l (vol_out_l),
   .vol_out_r (vol_out_r)
);

// File: tb/sim_dac_start_gate.sv
`timescale 1ns/1ps
module sim_dac_start_gate;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int VW = 8;
   localparam int N  = 1059;
   localparam int VDEF = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dac_en = 0, adc_l_en = 0, adc_r_en = 0, smp_stb = 0, alc_en = 0, vol_link = 1;
   logic [VW-1:0] vol_l = 8'h28, vol_r = 8'h10;
   logic [DW-1:0] din_l = '0, din_r = '0;
   logic [DW-1:0] dout_l, dout_r;
   logic init_busy, alc_hold, alc_load;
   logic [VW-1:0] vol_out_l, vol_out_r;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_start_gate u0 (
      .clk(clk), .rst_n(rst_n), .dac_en(dac_en), .adc_l_en(adc_l_en), .adc_r_en(adc_r_en),
      .smp_stb(smp_stb), .alc_en(alc_en), .vol_link(vol_link), .vol_l(vol_l), .vol_r(vol_r),
      .din_l(din_l), .din_r(din_r), .dout_l(dout_l), .dout_r(dout_r), .init_busy(init_busy),
      .alc_hold(alc_hold), .alc_load(alc_load), .vol_out_l(vol_out_l), .vol_out_r(vol_out_r)
   );

   int checks = 0, errors = 0, cycles = 0;
   int busy_strobes = 0, load_pulses = 0, stb_phase = 0;

   // behavioural reference state
   bit m_prev = 0, m_busy = 0;
   int m_cnt = 0;
   int m_vol [2] = '{VDEF, VDEF};

   function automatic bit m_start();
      return dac_en && !m_prev && !adc_l_en && !adc_r_en;
   endfunction
   function automatic bit m_pass();
      return dac_en && !m_busy && !m_start();
   endfunction
   function automatic int m_target(int ch);
      if (ch == 0 || vol_link) return int'(vol_l);
      return int'(vol_r);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev = 0; m_busy = 0; m_cnt = 0; m_vol[0] = VDEF; m_vol[1] = VDEF;
      end else begin
         bit st, ps;
         st = m_start(); ps = m_pass();
         if (!dac_en) begin
            m_busy = 0; m_cnt = 0; m_vol[0] = VDEF; m_vol[1] = VDEF;
         end else begin
            for (int ch = 0; ch < 2; ch++)
               if (ps && smp_stb) begin
                  if (m_vol[ch] < m_target(ch)) m_vol[ch]++;
                  else if (m_vol[ch] > m_target(ch)) m_vol[ch]--;
               end
            if (st) begin
               m_busy = 1; m_cnt = 0;
            end else if (m_busy && smp_stb) begin
               if (m_cnt == N - 1) begin m_busy = 0; m_cnt = 0; end
               else m_cnt++;
            end
         end
         m_prev = dac_en;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at t=%0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         int eo_l, eo_r;
         bit eh, el;
         eo_l = m_pass() ? int'(din_l) : 0;
         eo_r = m_pass() ? int'(din_r) : 0;
         eh = alc_en && dac_en && (m_busy || m_start());
         el = alc_en && dac_en && m_busy && smp_stb && (m_cnt == N - 1);
         chk(int'(dout_l) == eo_l, "R3 left data", int'(dout_l), eo_l);
         chk(int'(dout_r) == eo_r, "R3 right data", int'(dout_r), eo_r);
         chk(init_busy == m_busy, "R2 busy", int'(init_busy), int'(m_busy));
         chk(alc_hold == eh, "R6 alc hold", int'(alc_hold), int'(eh));
         chk(alc_load == el, "R7 alc load", int'(alc_load), int'(el));
         chk(int'(vol_out_l) == m_vol[0], "R8 left volume", int'(vol_out_l), m_vol[0]);
         chk(int'(vol_out_r) == m_vol[1], "R9 right volume", int'(vol_out_r), m_vol[1]);
         if (init_busy && smp_stb) busy_strobes++;
         if (alc_load) load_pulses++;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         stb_phase = (stb_phase + 1) % 4;
         smp_stb = (stb_phase == 0);
         din_l = DW'($urandom);
         din_r = DW'($urandom);
      end
   endtask

   task automatic run_window_and_count(input string req);
      busy_strobes = 0; load_pulses = 0;
      step(2);
      while (init_busy) step(1);
      step(1);
      chk(busy_strobes == N, req, busy_strobes, N);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(init_busy == 0 && alc_hold == 0 && alc_load == 0, "R1 flags", int'(init_busy), 0);
      chk(dout_l == '0 && dout_r == '0, "R1 data", int'(dout_l), 0);
      chk(vol_out_l == VW'(VDEF) && vol_out_r == VW'(VDEF), "R1 volume", int'(vol_out_l), VDEF);

      // R2 / R7: full window with ALC enabled, linked volume
      alc_en = 1; vol_link = 1;
      step(1); dac_en = 1;
      run_window_and_count("R2 window strobe count");
      chk(load_pulses == 1, "R7 load pulse count", load_pulses, 1);

      // R8 / R9: ramp up to 0x28 on both channels
      step(4 * 20);
      chk(vol_out_l == 8'h28, "R8 left ramp end", int'(vol_out_l), 'h28);
      chk(vol_out_r == 8'h28, "R9 linked right ramp end", int'(vol_out_r), 'h28);
      vol_link = 0;
      step(4 * 30);
      chk(vol_out_r == 8'h10, "R9 unlinked right ramp end", int'(vol_out_r), 'h10);

      // R10: ADC toggles with DAC held on start nothing
      adc_l_en = 1; step(8); adc_l_en = 0; adc_r_en = 1; step(8); adc_r_en = 0; step(8);
      chk(init_busy == 0, "R10 no window while on", int'(init_busy), 0);

      // R5: off clears, R4: enable with ADC on skips window
      dac_en = 0; step(5);
      chk(vol_out_l == VW'(VDEF), "R5 volume back to default", int'(vol_out_l), VDEF);
      adc_r_en = 1; dac_en = 1; step(1);
      chk(init_busy == 0, "R4 window skipped", int'(init_busy), 0);
      step(40);
      adc_r_en = 0;

      // R5: drop mid-window, re-enable gives a full window; R6 with ALC off
      dac_en = 0; step(3); dac_en = 1; step(4 * 500);
      chk(init_busy == 1, "R5 window running", int'(init_busy), 1);
      dac_en = 0; step(3);
      chk(init_busy == 0, "R5 window aborted", int'(init_busy), 0);
      alc_en = 0; dac_en = 1;
      run_window_and_count("R5 restarted window strobe count");
      chk(load_pulses == 0, "R6 R7 no ALC signals when disabled", load_pulses, 0);
      step(20);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule